// File: doc/BRIEF.md
# Mailbox Power-Cap Command Engine

This block serves a small byte-addressed mailbox shared between a host and a power-management engine. The host fills a command header (flag, request id, command code, big-endian 16-bit length and 16-bit argument word) and clears the response flag. It then marks the command ready. On each poll strobe the engine inspects the mailbox. A fresh command first moves the response into an in-progress state. The command executes on the next strobe.

The only command executed is "set power cap". Its argument is validated and clamped into the configured window, or a zero argument clears the cap back to the maximum. The engine writes the response body one clock before it publishes the ready flag and retires the command. It then pulses an output that tells the interrupt logic to raise its message and shared-memory bits. Any other command code gets an "unknown command" status. A response flag found in an unexpected state gets an "internal error" status.

Top module: `mbx_powercap_engine`

## Requirements
- R1: After reset the command flag, response flag and cap type read 0x00, the current cap reads 100, the engine state byte reads 0x03, the hard minimum reads 10 and the soft minimum reads 20.
- R2: On a clock without a poll strobe, or on a strobe while the command flag is not 0x80, no mailbox byte changes and no message pulse occurs.
- R3: On a strobe with command flag 0x80 and response flag 0x00, the only change is response flag = 0x02. The response body, the command flag and the cap are left as they were.
- R4: On a strobe with command flag 0x80 and a response flag other than 0x00 and 0x02, the engine answers with status 0x15 and length 0.
- R5: Command 0xD1 with a length other than 2 answers status 0x12, length 2, data = the current cap. The cap and cap type are unchanged.
- R6: Command 0xD1 of length 2 with argument 0 sets cap type 0x00 and cap 100, and answers status 0x00, length 2, data 100.
- R7: Command 0xD1 of length 2 with a nonzero argument sets cap type 0x02 and cap = the argument clamped to 10..100. It answers status 0x00, length 2, data = the new cap.
- R8: Any command code other than 0xD1 answers status 0x11 with length 0.
- R9: Every response copies the request id and the command code from the command header.
- R10: The response id, code, status, length and data are written on the executing strobe's clock edge. Response flag = 0x01 and command flag = 0x00 appear exactly one clock later.
- R11: The message output is high for exactly one clock per response. That clock is the first one in which response flag 0x01 is visible.
- R12: Host writes to addresses 16 to 25 have no effect. A strobe that arrives during the clock between body and flag publication starts nothing.
- R13: Byte map: 0 cmd flag, 1 cmd id, 2 cmd code, 3/4 cmd length hi/lo, 5/6 cmd data hi/lo, 8 rsp flag, 9 rsp id, 10 rsp code, 11 rsp status, 12/13 rsp length hi/lo, 14/15 rsp data hi/lo, 16 state, 17 cap type, 18/19 cap hi/lo, 20/21 hard min, 22/23 soft min, 24/25 cap maximum. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Poll strobe, one clock wide |
| wr_en | input | 1 | Host byte write enable |
| wr_addr | input | 5 | Host write byte address |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 5 | Host read byte address |
| rd_data | output | 8 | Byte at rd_addr, combinational |
| msg_raise | output | 1 | One-clock request to set the message and shared-memory interrupt bits |

## Verification
The mark of R3 is due at the clock edge that samples the first strobe. The response body is due at the edge that samples the executing strobe. The ready flag, retired command flag and message pulse follow one edge after the body, and the pulse is gone one edge after that. The bench drives every input on the falling edge. It reads the combinational read port just after the falling edge that follows each of those rising edges. This catches a response published one edge early or late, and a pulse that lasts longer than one clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // mailbox byte map
    localparam addr_t A_CMD_FLAG   = 5'd0;
    localparam addr_t A_CMD_ID     = 5'd1;
    localparam addr_t A_CMD_CODE   = 5'd2;
    localparam addr_t A_CMD_LEN_HI = 5'd3;
    localparam addr_t A_CMD_LEN_LO = 5'd4;
    localparam addr_t A_CMD_DAT_HI = 5'd5;
    localparam addr_t A_CMD_DAT_LO = 5'd6;
    localparam addr_t A_RSP_FLAG   = 5'd8;
    localparam addr_t A_RSP_ID     = 5'd9;
    localparam addr_t A_RSP_CODE   = 5'd10;
    localparam addr_t A_RSP_STATUS = 5'd11;
    localparam addr_t A_RSP_LEN_HI = 5'd12;
    localparam addr_t A_RSP_LEN_LO = 5'd13;
    localparam addr_t A_RSP_DAT_HI = 5'd14;
    localparam addr_t A_RSP_DAT_LO = 5'd15;
    localparam addr_t A_STATE      = 5'd16;
    localparam addr_t A_CAP_TYPE   = 5'd17;
    localparam addr_t A_CAP_HI     = 5'd18;
    localparam addr_t A_CAP_LO     = 5'd19;
    localparam addr_t A_HARD_HI    = 5'd20;
    localparam addr_t A_HARD_LO    = 5'd21;
    localparam addr_t A_SOFT_HI    = 5'd22;
    localparam addr_t A_SOFT_LO    = 5'd23;
    localparam addr_t A_MAX_HI     = 5'd24;
    localparam addr_t A_MAX_LO     = 5'd25;

    // flag encodings
    localparam byte_t CMD_READY = 8'h80;
    localparam byte_t RSP_IDLE  = 8'h00;
    localparam byte_t RSP_BUSY  = 8'h02;
    localparam byte_t RSP_DONE  = 8'h01;

    // response status codes
    localparam byte_t ST_OK       = 8'h00;
    localparam byte_t ST_BAD_CODE = 8'h11;
    localparam byte_t ST_BAD_LEN  = 8'h12;
    localparam byte_t ST_INTERNAL = 8'h15;

    localparam byte_t OP_SET_CAP    = 8'hD1;
    localparam byte_t CAPT_NONE     = 8'h00;
    localparam byte_t CAPT_USER     = 8'h02;
    localparam byte_t ENGINE_ACTIVE = 8'h03;
    localparam word_t CAP_ARG_LEN   = 16'd2;

    // decision produced for one executed command
    typedef struct packed {
        byte_t status;
        word_t len;
        logic  load_data;
        word_t data;
        logic  load_cap;
        word_t cap;
        byte_t cap_type;
    } verdict_t;

    typedef enum logic [1:0] {
        ENG_NONE,
        ENG_MARK,
        ENG_BODY,
        ENG_COMMIT
    } eng_op_t;

    typedef enum logic {
        SQ_IDLE,
        SQ_COMMIT
    } sq_state_t;

    function automatic word_t clamp_cap(word_t req, word_t lo, word_t hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction

    function automatic byte_t hi_byte(word_t w);
        return w[WORD_W-1:BYTE_W];
    endfunction

    function automatic byte_t lo_byte(word_t w);
        return w[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/mbx_cap_eval.sv
module mbx_cap_eval
    import mbx_pkg::*;
#(
    parameter word_t CAP_MAX = 16'd100,
    parameter word_t CAP_MIN = 16'd10
) (
    input  byte_t    code,
    input  word_t    arg_len,
    input  word_t    arg,
    input  word_t    cur_cap,
    input  logic     flag_ok,
    output verdict_t verdict
);
    always_comb begin
        verdict          = '0;
        verdict.cap      = cur_cap;
        verdict.cap_type = CAPT_NONE;
        if (!flag_ok) begin
            verdict.status = ST_INTERNAL;
        end else if (code != OP_SET_CAP) begin
            verdict.status = ST_BAD_CODE;
        end else if (arg_len != CAP_ARG_LEN) begin
            verdict.status    = ST_BAD_LEN;
            verdict.len       = CAP_ARG_LEN;
            verdict.load_data = 1'b1;
            verdict.data      = cur_cap;
        end else begin
            verdict.status    = ST_OK;
            verdict.len       = CAP_ARG_LEN;
            verdict.load_data = 1'b1;
            verdict.load_cap  = 1'b1;
            if (arg == '0) begin
                verdict.cap      = CAP_MAX;
                verdict.cap_type = CAPT_NONE;
            end else begin
                verdict.cap      = clamp_cap(arg, CAP_MIN, CAP_MAX);
                verdict.cap_type = CAPT_USER;
            end
            verdict.data = verdict.cap;
        end
    end
endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
    import mbx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  byte_t   cmd_flag,
    input  byte_t   rsp_flag,
    output eng_op_t op,
    output logic    flag_ok,
    output logic    busy,
    output logic    msg_raise
);
    sq_state_t state_q, state_d;
    logic      pending;

    assign pending = (cmd_flag == CMD_READY);
    assign flag_ok = (rsp_flag == RSP_BUSY);
    assign busy    = (state_q == SQ_COMMIT);

    always_comb begin
        op      = ENG_NONE;
        state_d = state_q;
        case (state_q)
            SQ_IDLE: begin
                if (tick && pending) begin
                    if (rsp_flag == RSP_IDLE) begin
                        op = ENG_MARK;
                    end else begin
                        op      = ENG_BODY;
                        state_d = SQ_COMMIT;
                    end
                end
            end
            SQ_COMMIT: begin
                op      = ENG_COMMIT;
                state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            msg_raise <= 1'b0;
        end else begin
            state_q   <= state_d;
            msg_raise <= (state_q == SQ_COMMIT);
        end
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter word_t CAP_MAX  = 16'd100,
    parameter word_t CAP_HARD = 16'd10,
    parameter word_t CAP_SOFT = 16'd20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  addr_t    wr_addr,
    input  byte_t    wr_data,
    input  addr_t    rd_addr,
    output byte_t    rd_data,
    input  eng_op_t  op,
    input  verdict_t verdict,
    output byte_t    cmd_flag,
    output byte_t    cmd_code,
    output word_t    cmd_len,
    output word_t    cmd_data,
    output byte_t    rsp_flag,
    output word_t    cap,
    output byte_t    cap_type
);
    byte_t c_flag, c_id, c_code;
    word_t c_len, c_data;
    byte_t r_flag, r_id, r_code, r_status;
    word_t r_len, r_data;
    word_t cap_q;
    byte_t type_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_flag   <= '0;
            c_id     <= '0;
            c_code   <= '0;
            c_len    <= '0;
            c_data   <= '0;
            r_flag   <= RSP_IDLE;
            r_id     <= '0;
            r_code   <= '0;
            r_status <= '0;
            r_len    <= '0;
            r_data   <= '0;
            cap_q    <= CAP_MAX;
            type_q   <= CAPT_NONE;
        end else begin
            // host side first, engine updates below take precedence
            if (wr_en) begin
                case (wr_addr)
                    A_CMD_FLAG:   c_flag               <= wr_data;
                    A_CMD_ID:     c_id                 <= wr_data;
                    A_CMD_CODE:   c_code               <= wr_data;
                    A_CMD_LEN_HI: c_len[WORD_W-1:BYTE_W]  <= wr_data;
                    A_CMD_LEN_LO: c_len[BYTE_W-1:0]       <= wr_data;
                    A_CMD_DAT_HI: c_data[WORD_W-1:BYTE_W] <= wr_data;
                    A_CMD_DAT_LO: c_data[BYTE_W-1:0]      <= wr_data;
                    A_RSP_FLAG:   r_flag               <= wr_data;
                    A_RSP_ID:     r_id                 <= wr_data;
                    A_RSP_CODE:   r_code               <= wr_data;
                    A_RSP_STATUS: r_status             <= wr_data;
                    A_RSP_LEN_HI: r_len[WORD_W-1:BYTE_W]  <= wr_data;
                    A_RSP_LEN_LO: r_len[BYTE_W-1:0]       <= wr_data;
                    A_RSP_DAT_HI: r_data[WORD_W-1:BYTE_W] <= wr_data;
                    A_RSP_DAT_LO: r_data[BYTE_W-1:0]      <= wr_data;
                    default: ;
                endcase
            end
            case (op)
                ENG_MARK: r_flag <= RSP_BUSY;
                ENG_BODY: begin
                    r_id     <= c_id;
                    r_code   <= c_code;
                    r_status <= verdict.status;
                    r_len    <= verdict.len;
                    if (verdict.load_data) r_data <= verdict.data;
                    if (verdict.load_cap) begin
                        cap_q  <= verdict.cap;
                        type_q <= verdict.cap_type;
                    end
                end
                ENG_COMMIT: begin
                    r_flag <= RSP_DONE;
                    c_flag <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_CMD_FLAG:   rd_data = c_flag;
            A_CMD_ID:     rd_data = c_id;
            A_CMD_CODE:   rd_data = c_code;
            A_CMD_LEN_HI: rd_data = hi_byte(c_len);
            A_CMD_LEN_LO: rd_data = lo_byte(c_len);
            A_CMD_DAT_HI: rd_data = hi_byte(c_data);
            A_CMD_DAT_LO: rd_data = lo_byte(c_data);
            A_RSP_FLAG:   rd_data = r_flag;
            A_RSP_ID:     rd_data = r_id;
            A_RSP_CODE:   rd_data = r_code;
            A_RSP_STATUS: rd_data = r_status;
            A_RSP_LEN_HI: rd_data = hi_byte(r_len);
            A_RSP_LEN_LO: rd_data = lo_byte(r_len);
            A_RSP_DAT_HI: rd_data = hi_byte(r_data);
            A_RSP_DAT_LO: rd_data = lo_byte(r_data);
            A_STATE:      rd_data = ENGINE_ACTIVE;
            A_CAP_TYPE:   rd_data = type_q;
            A_CAP_HI:     rd_data = hi_byte(cap_q);
            A_CAP_LO:     rd_data = lo_byte(cap_q);
            A_HARD_HI:    rd_data = hi_byte(CAP_HARD);
            A_HARD_LO:    rd_data = lo_byte(CAP_HARD);
            A_SOFT_HI:    rd_data = hi_byte(CAP_SOFT);
            A_SOFT_LO:    rd_data = lo_byte(CAP_SOFT);
            A_MAX_HI:     rd_data = hi_byte(CAP_MAX);
            A_MAX_LO:     rd_data = lo_byte(CAP_MAX);
            default:      rd_data = '0;
        endcase
    end

    assign cmd_flag = c_flag;
    assign cmd_code = c_code;
    assign cmd_len  = c_len;
    assign cmd_data = c_data;
    assign rsp_flag = r_flag;
    assign cap      = cap_q;
    assign cap_type = type_q;
endmodule

// File: rtl/mbx_powercap_engine.sv
module mbx_powercap_engine
    import mbx_pkg::*;
#(
    parameter int unsigned CAP_MAX_W      = 100,
    parameter int unsigned CAP_HARD_MIN_W = 10,
    parameter int unsigned CAP_SOFT_MIN_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              msg_raise
);
    localparam word_t CAP_MAX_V  = word_t'(CAP_MAX_W);
    localparam word_t CAP_HARD_V = word_t'(CAP_HARD_MIN_W);
    localparam word_t CAP_SOFT_V = word_t'(CAP_SOFT_MIN_W);

    eng_op_t  op;
    verdict_t verdict;
    logic     flag_ok;
    logic     seq_busy;
    byte_t    cmd_flag, cmd_code, rsp_flag, cap_type;
    word_t    cmd_len, cmd_data, cap;

    mbx_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd_flag  (cmd_flag),
        .rsp_flag  (rsp_flag),
        .op        (op),
        .flag_ok   (flag_ok),
        .busy      (seq_busy),
        .msg_raise (msg_raise)
    );

    mbx_cap_eval #(
        .CAP_MAX (CAP_MAX_V),
        .CAP_MIN (CAP_HARD_V)
    ) u_eval (
        .code    (cmd_code),
        .arg_len (cmd_len),
        .arg     (cmd_data),
        .cur_cap (cap),
        .flag_ok (flag_ok),
        .verdict (verdict)
    );

    mbx_regfile #(
        .CAP_MAX  (CAP_MAX_V),
        .CAP_HARD (CAP_HARD_V),
        .CAP_SOFT (CAP_SOFT_V)
    ) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .op       (op),
        .verdict  (verdict),
        .cmd_flag (cmd_flag),
        .cmd_code (cmd_code),
        .cmd_len  (cmd_len),
        .cmd_data (cmd_data),
        .rsp_flag (rsp_flag),
        .cap      (cap),
        .cap_type (cap_type)
    );
endmodule

// File: rtl/mbx_powercap_checker.sv
module mbx_powercap_checker
    import mbx_pkg::*;
#(
    parameter int unsigned CAP_MAX_W      = 100,
    parameter int unsigned CAP_HARD_MIN_W = 10
) (
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  wr_en,
    input addr_t wr_addr,
    input logic  msg_raise,
    input logic  busy,
    input byte_t cmd_flag,
    input byte_t rsp_flag,
    input word_t cap,
    input byte_t cap_type
);
    localparam word_t HI = word_t'(CAP_MAX_W);
    localparam word_t LO = word_t'(CAP_HARD_MIN_W);

    logic host_rsp_flag_wr;
    assign host_rsp_flag_wr = wr_en && (wr_addr == A_RSP_FLAG);

    a_r7_cap_in_window: assert property (@(posedge clk) disable iff (rst)
        (cap >= LO) && (cap <= HI));

    a_r6_cleared_cap_at_max: assert property (@(posedge clk) disable iff (rst)
        (cap_type == CAPT_NONE) |-> (cap == HI));

    a_r10_commit_publishes: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rsp_flag == RSP_DONE) && (cmd_flag == 8'h00));

    a_r11_raise_after_commit: assert property (@(posedge clk) disable iff (rst)
        busy |=> msg_raise);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        msg_raise |=> !msg_raise);

    a_r11_no_spurious_raise: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !msg_raise);

    a_r2_quiet_without_command: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(tick && cmd_flag == CMD_READY) && !host_rsp_flag_wr)
        |=> $stable(rsp_flag));

    a_r3_mark_in_progress: assert property (@(posedge clk) disable iff (rst)
        (!busy && tick && cmd_flag == CMD_READY && rsp_flag == RSP_IDLE && !host_rsp_flag_wr)
        |=> (rsp_flag == RSP_BUSY) && !busy);
endmodule

bind mbx_powercap_engine mbx_powercap_checker #(
    .CAP_MAX_W      (CAP_MAX_W),
    .CAP_HARD_MIN_W (CAP_HARD_MIN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .msg_raise (msg_raise),
    .busy      (seq_busy),
    .cmd_flag  (cmd_flag),
    .rsp_flag  (rsp_flag),
    .cap       (cap),
    .cap_type  (cap_type)
);

// File: tb/mbx_powercap_engine_tb.sv
`timescale 1ns/1ps
module mbx_powercap_engine_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       msg_raise;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int model_cap  = 100;
    int model_type = 0;

    always #2.5 clk = ~clk;

    mbx_powercap_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .msg_raise (msg_raise)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wbyte(input int a, input int d);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rbyte(input int a, output int v);
        rd_addr = 5'(a);
        #0.05;
        v = int'(rd_data);
    endtask

    task automatic rword(input int a, output int v);
        int h, l;
        rbyte(a, h);
        rbyte(a + 1, l);
        v = (h << 8) | l;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_cmd(input int id, input int code, input int len, input int data, input int rflag);
        wbyte(1, id);
        wbyte(2, code);
        wbyte(3, (len >> 8) & 8'hFF);
        wbyte(4, len & 8'hFF);
        wbyte(5, (data >> 8) & 8'hFF);
        wbyte(6, data & 8'hFF);
        wbyte(8, rflag);
        wbyte(0, 8'h80);
    endtask

    // expected response from the requirements
    function automatic void model(input int code, input int len, input int data,
                                  output int st, output int rlen, output int rdata, output bit has_data);
        has_data = 1'b0; rdata = 0;
        if (code != 8'hD1) begin
            st = 8'h11; rlen = 0;                                   // R8
        end else if (len != 2) begin
            st = 8'h12; rlen = 2; rdata = model_cap; has_data = 1'b1;  // R5
        end else if (data == 0) begin
            model_cap = 100; model_type = 0;                        // R6
            st = 0; rlen = 2; rdata = 100; has_data = 1'b1;
        end else begin
            model_cap = (data < 10) ? 10 : ((data > 100) ? 100 : data); // R7
            model_type = 2;
            st = 0; rlen = 2; rdata = model_cap; has_data = 1'b1;
        end
    endfunction

    task automatic check_body(input int id, input int code, input int st, input int rlen,
                              input int rdata, input bit has_data);
        int v;
        rbyte(9, v);   check("R9", "rsp id", v, id);
        rbyte(10, v);  check("R9", "rsp code", v, code);
        rbyte(11, v);  check("R4/R5/R6/R7/R8", "status", v, st);
        rword(12, v);  check("R5/R6/R7", "rsp length", v, rlen);
        if (has_data) begin
            rword(14, v); check("R5/R6/R7", "rsp data", v, rdata);
        end
        rbyte(8, v);   check("R10", "flag before commit", v, 8'h02 & ((st == 8'h15) ? 8'h00 : 8'hFF) | ((st == 8'h15) ? -1 : 0));
    endtask

    task automatic check_commit();
        int v;
        @(negedge clk);
        rbyte(8, v);  check("R10", "rsp flag after commit", v, 8'h01);
        rbyte(0, v);  check("R10", "cmd flag after commit", v, 8'h00);
        check("R11", "msg_raise with ready flag", int'(msg_raise), 1);
        @(negedge clk);
        check("R11", "msg_raise one clock", int'(msg_raise), 0);
        rword(18, v); check("R5/R6/R7", "current cap", v, model_cap);
        rbyte(17, v); check("R6/R7", "cap type", v, model_type);
    endtask

    // full two-strobe transaction
    task automatic run_cmd(input int id, input int code, input int len, input int data);
        int v, st, rlen, rdata, old_st;
        bit hd;
        load_cmd(id, code, len, data, 0);
        rbyte(11, old_st);
        do_tick();
        rbyte(8, v);  check("R3", "rsp flag marked", v, 8'h02);
        rbyte(0, v);  check("R3", "cmd flag kept", v, 8'h80);
        rbyte(11, v); check("R3", "status untouched", v, old_st);
        check("R3", "no msg on mark", int'(msg_raise), 0);
        do_tick();
        model(code, len, data, st, rlen, rdata, hd);
        check_body(id, code, st, rlen, rdata, hd);
        rbyte(0, v);  check("R10", "cmd flag before commit", v, 8'h80);
        check("R11", "no msg before commit", int'(msg_raise), 0);
        check_commit();
    endtask

    initial begin
        int v, lastflag;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rbyte(0, v);  check("R1", "cmd flag", v, 0);
        rbyte(8, v);  check("R1", "rsp flag", v, 0);
        rbyte(17, v); check("R1", "cap type", v, 0);
        rword(18, v); check("R1", "cap", v, 100);
        rbyte(16, v); check("R1", "state", v, 3);
        rword(20, v); check("R1", "hard min", v, 10);
        rword(22, v); check("R1", "soft min", v, 20);
        rword(24, v); check("R13", "cap max", v, 100);

        // R2 strobe with a non-ready flag, and ready flag without strobe
        load_cmd(8'h11, 8'hD1, 2, 50, 0);
        wbyte(0, 8'h7F);
        do_tick();
        rbyte(8, v);  check("R2", "rsp flag after idle strobe", v, 0);
        check("R2", "no msg", int'(msg_raise), 0);
        wbyte(0, 8'h80);
        repeat (4) @(negedge clk);
        rbyte(8, v);  check("R2", "rsp flag without strobe", v, 0);
        rword(18, v); check("R2", "cap unchanged", v, 100);
        wbyte(0, 8'h00);

        // directed corner cases
        run_cmd(8'h21, 8'hD1, 2, 55);       // R7 in range
        run_cmd(8'h22, 8'hD1, 2, 3);        // R7 below hard minimum
        run_cmd(8'h23, 8'hD1, 2, 16'hFFFF); // R7 above maximum
        run_cmd(8'h24, 8'hD1, 2, 10);       // R7 boundary
        run_cmd(8'h25, 8'hD1, 3, 40);       // R5 bad length
        run_cmd(8'h26, 8'hD1, 2, 0);        // R6 clear
        run_cmd(8'h27, 8'h42, 2, 40);       // R8 other code

        // R4 unexpected response flag (stale ready flag 0x01)
        begin
            int st, rlen, rdata;
            load_cmd(8'h31, 8'hD1, 2, 70, 8'h01);
            do_tick();
            st = 8'h15; rlen = 0; rdata = 0;
            rbyte(9, v);  check("R9", "rsp id on error", v, 8'h31);
            rbyte(11, v); check("R4", "internal error status", v, st);
            rword(12, v); check("R4", "internal error length", v, rlen);
            rbyte(8, v);  check("R10", "flag before commit (error)", v, 8'h01);
            check_commit();
            rword(18, v); check("R4", "cap untouched on error", v, model_cap);
        end

        // R12 writes to the read-only area are ignored
        for (int a = 16; a <= 25; a++) wbyte(a, 8'hAA);
        rbyte(16, v); check("R12", "state after write", v, 3);
        rword(18, v); check("R12", "cap after write", v, model_cap);
        rbyte(17, v); check("R12", "cap type after write", v, model_type);
        rword(20, v); check("R12", "hard min after write", v, 10);

        // R12 strobe held through the commit clock starts nothing new
        begin
            int pulses;
            pulses = 0;
            load_cmd(8'h41, 8'hD1, 2, 60, 0);
            tick = 1'b1;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (msg_raise) pulses++;
            end
            tick = 1'b0;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                if (msg_raise) pulses++;
            end
            model_cap = 60; model_type = 2;
            check("R12", "one pulse with strobe held", pulses, 1);
            rbyte(8, v);  check("R12", "rsp flag stays ready", v, 8'h01);
            rword(18, v); check("R7", "cap after held strobe", v, 60);
        end

        // randomized transactions
        for (int n = 0; n < 40; n++) begin
            int code, len, data, sel;
            code = ($urandom_range(0, 9) < 7) ? 8'hD1 : int'($urandom_range(0, 255));
            len  = ($urandom_range(0, 9) < 8) ? 2 : int'($urandom_range(0, 65535));
            sel  = $urandom_range(0, 5);
            case (sel)
                0: data = 0;
                1: data = $urandom_range(1, 9);
                2: data = $urandom_range(10, 100);
                3: data = $urandom_range(101, 65535);
                4: data = ($urandom_range(0, 1) != 0) ? 10 : 100;
                default: data = $urandom_range(0, 65535);
            endcase
            run_cmd(int'($urandom_range(0, 255)), code, len, data);
        end

        rbyte(8, lastflag);
        check("R10", "final rsp flag", lastflag, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule